// File: doc/BRIEF.md
# Hit-Gated Identifier Frame Sequencer

This block drives the load-modulation bit of a passive tag. While it is switched on, it sends a framed identifier over and over. Each frame carries an 8-bit code, most significant bit first, followed by eight 1 bits. The eight 1 bits mark the end of the frame. One bit goes out for each pulse on a bit-rate tick input, and a strobe marks the first code bit of every frame.

The block does not start at power-up. It stays silent until the uplink decoder reports a matching reader command as a one-cycle hit pulse. Each hit flips the transmit state, so the reader can wake a tag with one command and silence it with a later one. When the block is switched off, it drops the frame in progress and holds the drive bit at 0, so no load modulation takes place. When it is switched on again, it restarts at the first code bit.

Top module: `tcs_code_sequencer`

## Requirements
- R1: Reset clears the transmit state and drives `mod_out` and `frame_start` to 0. After reset is released, ticks without a hit leave the block silent.
- R2: While transmission is off, `mod_out` stays 0 and `frame_start` stays 0 regardless of `bit_tick`.
- R3: A hit while off switches transmission on. The first tick after that puts `code[7]` on `mod_out` and pulses `frame_start`.
- R4: Code bits go out in the order `code[7]` down to `code[0]`, one per tick. Each output change is visible one clock after the tick. Between ticks, `mod_out` holds its value.
- R5: After the eighth code bit, the next eight ticks each drive `mod_out` to 1.
- R6: Frames follow each other with no gap. The tick after the last delimiter 1 sends `code[7]` of the next frame.
- R7: A hit while on switches transmission off. One clock later `mod_out` is 0. The frame position is discarded, and the next enable restarts at `code[7]`.
- R8: When a hit and a tick fall in the same cycle, the on/off change applies first. Turning on with that tick sends `code[7]` with `frame_start`. Turning off with that tick drives 0.
- R9: The code is sampled at each tick for the bit being sent, so a new value on `code` takes effect from the next bit sent. The value 01010011 gives the stream 0,1,0,1,0,0,1,1 followed by eight 1 bits.
- R10: `frame_start` is high for exactly one clock per frame, in the cycle after the tick that sends the frame's first code bit. It is never high for other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse at the downlink bit rate |
| hit | input | 1 | One-cycle pulse from the uplink decoder; toggles transmission |
| code | input | 8 | Identifier to transmit, MSB first |
| mod_out | output | 1 | Drive bit for the load modulator |
| frame_start | output | 1 | One-cycle strobe on the first code bit of each frame |

## Verification
The hardest case to reach is a hit that lands in the same cycle as a bit tick. Turning off in that cycle must suppress the bit, and turning on must send `code[7]` with the strobe, with no idle slot first. The stimulus table places hit and tick together in both directions, at positions inside a frame. It also changes the code in the middle of a frame, so per-tick sampling shows up at the output. A directed run then ticks every cycle through more than a full frame and puts reset in the middle of an active frame.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int unsigned TCS_CODE_W  = 8;
    localparam int unsigned TCS_DELIM_W = 8;

    typedef struct packed {
        logic mod;
        logic fs;
    } tcs_out_t;

    typedef struct packed {
        logic en;
    } tcs_en_t;

endpackage

// File: rtl/tcs_enable_ctl.sv
module tcs_enable_ctl
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic en_now,
    output logic start,
    output logic en_state
);

    tcs_en_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = st_q.en ^ hit;
        en_now  = st_d.en;
        start   = hit & ~st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_state = st_q.en;

    // R3 / R7: every hit flips the registered state
    a_r3_hit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (en_state != $past(en_state)));

    // R2: without a hit the state holds
    a_r2_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(en_state));

endmodule

// File: rtl/tcs_slot_counter.sv
module tcs_slot_counter #(
    parameter int unsigned FRAME_LEN = 16,
    localparam int unsigned PW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [PW-1:0] cur_pos
);

    localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        cur_pos = clear ? '0 : cnt_q.pos;
        if (advance) begin
            if (cur_pos == LAST) cnt_d.pos = '0;
            else                 cnt_d.pos = cur_pos + 1'b1;
        end else begin
            cnt_d.pos = cur_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: position never leaves the frame
    a_r6_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q.pos) < FRAME_LEN);

    // R7: a cleared counter without advance rests at slot zero
    a_r7_clear_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !advance) |=> (cnt_q.pos == '0));

endmodule

// File: rtl/tcs_bit_select.sv
module tcs_bit_select #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned PW     = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic [PW-1:0]     pos,
    output logic              bit_o
);

    always_comb begin
        bit_o = 1'b1;
        for (int i = 0; i < CODE_W; i++) begin
            if (int'(pos) == i) bit_o = code[CODE_W-1-i];
        end
    end

endmodule

// File: rtl/tcs_code_sequencer.sv
module tcs_code_sequencer
    import tcs_pkg::*;
#(
    parameter int unsigned CODE_W  = TCS_CODE_W,
    parameter int unsigned DELIM_W = TCS_DELIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    output logic              mod_out,
    output logic              frame_start
);

    localparam int unsigned FRAME_LEN = CODE_W + DELIM_W;
    localparam int unsigned PW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    logic          en_now;
    logic          start;
    logic          en_state;
    logic [PW-1:0] cur_pos;
    logic          tx_bit;
    logic          advance;

    tcs_out_t out_d, out_q;

    tcs_enable_ctl u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .en_now   (en_now),
        .start    (start),
        .en_state (en_state)
    );

    assign advance = bit_tick & en_now;

    tcs_slot_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (~en_now | start),
        .advance (advance),
        .cur_pos (cur_pos)
    );

    tcs_bit_select #(.CODE_W(CODE_W), .PW(PW)) u_sel (
        .code  (code),
        .pos   (cur_pos),
        .bit_o (tx_bit)
    );

    always_comb begin
        out_d    = out_q;
        out_d.fs = 1'b0;
        if (!en_now) begin
            out_d.mod = 1'b0;
        end else if (advance) begin
            out_d.mod = tx_bit;
            out_d.fs  = (cur_pos == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mod_out     = out_q.mod;
    assign frame_start = out_q.fs;

    // R2: silent while off
    a_r2_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_state |-> (!mod_out && !frame_start));

    // R4: output holds between ticks
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !hit) |=> $stable(mod_out));

    // R5: delimiter slots drive ones
    a_r5_delim_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && int'(cur_pos) >= CODE_W) |=> mod_out);

    // R7: switching off forces the drive low on the next clock
    a_r7_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && en_state) |=> (!mod_out && !frame_start));

    // R8: enable and tick together start a frame at once
    a_r8_hit_tick_start: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !en_state && bit_tick) |=> frame_start);

    // R10: strobe is one clock wide unless a new frame begins
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bit_tick) |=> !frame_start);

endmodule

// File: tb/tcs_code_sequencer_tb.sv
`timescale 1ns/1ps
module tcs_code_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       hit = 1'b0;
    logic [7:0] code = 8'h00;
    logic       mod_out;
    logic       frame_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tcs_code_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .hit         (hit),
        .code        (code),
        .mod_out     (mod_out),
        .frame_start (frame_start)
    );

    // {req[3:0], hit, tick, code[7:0], exp_mod, exp_fs}
    localparam int NV = 33;
    localparam logic [15:0] VEC [NV] = '{
        {4'd2,  1'b0, 1'b1, 8'h53, 1'b0, 1'b0}, // R2 tick while off
        {4'd3,  1'b1, 1'b0, 8'h53, 1'b0, 1'b0}, // R3 enable, no tick yet
        {4'd3,  1'b0, 1'b1, 8'h53, 1'b0, 1'b1}, // R3 code[7]=0 with strobe
        {4'd10, 1'b0, 1'b0, 8'h53, 1'b0, 1'b0}, // R10 strobe dropped
        {4'd9,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0}, // R9 bit1
        {4'd4,  1'b0, 1'b1, 8'h53, 1'b0, 1'b0}, // R4 bit2
        {4'd4,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0}, // R4 bit3
        {4'd4,  1'b0, 1'b1, 8'h53, 1'b0, 1'b0}, // R4 bit4
        {4'd4,  1'b0, 1'b1, 8'h53, 1'b0, 1'b0}, // R4 bit5
        {4'd4,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0}, // R4 bit6
        {4'd9,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0}, // R9 bit7
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0}, // R5 delimiter 1..8
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd6,  1'b0, 1'b1, 8'h53, 1'b0, 1'b1}, // R6 next frame, no gap
        {4'd6,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd7,  1'b1, 1'b0, 8'h53, 1'b0, 1'b0}, // R7 disable mid-frame
        {4'd7,  1'b0, 1'b1, 8'h53, 1'b0, 1'b0}, // R7 stays silent
        {4'd8,  1'b1, 1'b1, 8'h53, 1'b0, 1'b1}, // R8 enable+tick restarts at code[7]
        {4'd8,  1'b0, 1'b1, 8'h53, 1'b1, 1'b0},
        {4'd8,  1'b1, 1'b1, 8'h53, 1'b0, 1'b0}, // R8 disable+tick is silent
        {4'd8,  1'b1, 1'b1, 8'hA5, 1'b1, 1'b1}, // R8 enable+tick with new code
        {4'd10, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0}, // R10 strobe single, R4 hold
        {4'd9,  1'b0, 1'b1, 8'h0F, 1'b0, 1'b0}, // R9 code changed mid-frame
        {4'd9,  1'b0, 1'b1, 8'h0F, 1'b0, 1'b0},
        {4'd9,  1'b0, 1'b1, 8'h0F, 1'b0, 1'b0},
        {4'd9,  1'b0, 1'b1, 8'h0F, 1'b1, 1'b0},
        {4'd7,  1'b1, 1'b0, 8'h0F, 1'b0, 1'b0}  // R7 final disable
    };

    task automatic check(input logic em, input logic ef, input string tag);
        n_chk++;
        if (mod_out !== em || frame_start !== ef) begin
            n_bad++;
            $display("FAIL %s: mod_out=%b frame_start=%b, expected mod_out=%b frame_start=%b",
                     tag, mod_out, frame_start, em, ef);
        end
    endtask

    task automatic step(input logic h, input logic t, input logic [7:0] c);
        @(negedge clk);
        hit = h; bit_tick = t; code = c;
        @(posedge clk);
        #1;
        hit = 1'b0; bit_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9:2]);
            check(VEC[i][1], VEC[i][0], $sformatf("R%0d table step %0d", VEC[i][15:12], i));
        end

        // R1: reset in the middle of an active frame, then silence after release
        step(1'b1, 1'b1, 8'hFF);
        check(1'b1, 1'b1, "R3 enable before reset");
        step(1'b0, 1'b1, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1'b0, 1'b0, "R1 async reset mid-frame");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 8'hFF);
            check(1'b0, 1'b0, "R1 silent after reset");
        end

        // R5/R6/R10: tick every cycle through more than one frame, code 0xC3
        for (int i = 0; i < 18; i++) begin
            logic [7:0] c;
            logic em;
            int k;
            c = 8'hC3;
            k = i % 16;
            em = (k < 8) ? c[7-k] : 1'b1;
            step(i == 0, 1'b1, c);
            check(em, (k == 0), $sformatf("R6 back-to-back slot %0d", i));
        end
        step(1'b1, 1'b0, 8'hC3);
        check(1'b0, 1'b0, "R7 off after burst");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule